// File: doc/BRIEF.md
# Mixed-Precision SIMD Approximate Multiply-Divide Array

This block treats two 32-bit operand words as a set of independent lanes and runs an approximate logarithmic (Mitchell) multiply or divide in each lane. A one-hot precision code chooses how the word is cut into lanes. There are four possible cuts: one 32-bit lane, two 16-bit lanes, one 16-bit lane with two 8-bit lanes, or four 8-bit lanes. A mode bit per lane chooses the operation, so one issue can mix lane widths and mix multiplies with divides.

Each lane takes the approximate base-2 logarithm of its operands. A leading-one detector works on 4-bit nibbles and gives the integer part, and the bits below the leading one form the fraction. The fraction adder is made of four 8-bit slices. A slice takes the carry of the slice below it only when both slices belong to the same lane, so one set of slices serves every lane width. A divide adds the inverted divisor fraction with the slice carry-in set, which forms a two's-complement subtract. The top bit of the lane sum then marks either a fraction overflow (multiply) or a negative difference (divide). A shifter per lane applies the anti-logarithm. The packed result is registered, so results appear one cycle after the operands are accepted.

Top module: `smdMixArray`

## Requirements
- R1: `precSel` picks the lane layout. 4'b0001 gives four 8-bit lanes at bit offsets 0, 8, 16 and 24. 4'b0010 gives a 16-bit lane at offset 0 and 8-bit lanes at offsets 16 and 24. 4'b0100 gives two 16-bit lanes at offsets 0 and 16. 4'b1000 gives one 32-bit lane. A lane that starts at operand bit 8·s puts its result at `resOut` bit 16·s.
- R2: Any `precSel` value that is not one-hot, including zero, acts exactly like four 8-bit lanes.
- R3: A lane that starts at slice s (operand bit 8·s) divides when `modeDiv[s]` is 1 and multiplies when it is 0. The mode bits of slices inside a wider lane have no effect.
- R4: A multiply in a lane of width W with nonzero operands works as follows. Let k be the leading-one position of each operand and f its bits below the leading one, scaled to W−1 fraction bits. Let S = fa+fb. If S < 2^(W−1), the result is ((2^(W−1)+S)·2^(ka+kb)) >> (W−1). Otherwise it is (S·2^(ka+kb+1)) >> (W−1). The 2W-bit result fills the lane's output field.
- R5: A divide in a lane of width W uses only the low W/2 bits of that lane of `opB` as the divisor; the upper half of the lane of `opB` is ignored. Both fractions are scaled to W−1 bits and D = fa−fb. If D ≥ 0, the quotient is (2^(W−1)+D) >> (W−1−ka+kb). If D < 0, the quotient is (2^W+D) >> (W−ka+kb). The quotient fills the low W bits of the output field, and the upper W bits are zero.
- R6: A multiply with a zero operand gives 0. A divide by a zero divisor gives all ones in the low W bits and zero in the upper W bits. A zero dividend with a nonzero divisor gives 0.
- R7: Carries never cross a lane boundary, so each lane's result depends only on that lane's operands and mode, even when all fractions are at their maximum.
- R8: `validOut` is 1 exactly one cycle after a cycle with `validIn` = 1, and `resOut` then holds the result for the operands, `precSel` and `modeDiv` sampled in that cycle.
- R9: While `validIn` is 0, `resOut` keeps its last value whatever the other inputs do.
- R10: After reset, `validOut` is 0 and `resOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Accepts operands, precision and modes this cycle |
| precSel | input | 4 | One-hot lane layout code |
| modeDiv | input | 4 | Per-lane divide select, indexed by the lane's first slice |
| opA | input | 32 | Packed multiplicands / dividends |
| opB | input | 32 | Packed multipliers / divisors |
| validOut | output | 1 | Result valid, one cycle after validIn |
| resOut | output | 64 | Packed lane results, 16·s bit offset per lane starting at slice s |

## Verification
Every lane result is due exactly one clock edge after the edge at which `validIn` was sampled high. The driver applies stimulus on the falling edge and pushes the expected 64-bit word, computed from the lane formulas, into a queue. The monitor pops one entry on each falling edge where `validOut` is high, which is half a cycle after the result register loads. An unexpected `validOut`, or an entry left in the queue at the end, counts as a failure. The hold behaviour is checked on the falling edges of idle cycles against the last word popped.

// File: rtl/smdPkg.sv
package smdPkg;
  localparam int SLICE_W = 8;
  localparam int NSLICE  = 4;
  localparam int WORD_W  = SLICE_W * NSLICE;
  localparam int RES_W   = 2 * WORD_W;

  typedef enum logic [1:0] {
    CFG_Q8  = 2'd0,
    CFG_M16 = 2'd1,
    CFG_D16 = 2'd2,
    CFG_S32 = 2'd3
  } cfgE;

  // strobes from control to datapath
  typedef struct packed {
    cfgE               cfg;
    logic [NSLICE-1:0] carryPass;  // bit s: slice s takes carry of slice s-1
    logic [NSLICE-1:0] sliceDiv;   // slice belongs to a divide lane
    logic              capture;
  } ctrlS;
endpackage

// File: rtl/smdLod.sv
module smdLod #(
  parameter int W = 8,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [KW-1:0] pos,
  output logic          isZero
);
  localparam int NN = W / 4;

  logic [NN-1:0] nibNz;
  logic [1:0]    nibPos [NN];

  for (genvar n = 0; n < NN; n++) begin : gNib
    assign nibNz[n] = |vec[4*n +: 4];
    always_comb begin
      if (vec[4*n+3])      nibPos[n] = 2'd3;
      else if (vec[4*n+2]) nibPos[n] = 2'd2;
      else if (vec[4*n+1]) nibPos[n] = 2'd1;
      else                 nibPos[n] = 2'd0;
    end
  end

  always_comb begin
    pos = '0;
    for (int n = 0; n < NN; n++) begin
      if (nibNz[n]) pos = KW'(4 * n + int'(nibPos[n]));
    end
  end

  assign isZero = ~|nibNz;
endmodule

// File: rtl/smdLogStage.sv
module smdLogStage #(
  parameter int W = 8,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          isDiv,
  output logic [W-1:0]  fracA,
  output logic [W-1:0]  fracB,
  output logic [KW-1:0] expA,
  output logic [KW-1:0] expB,
  output logic          zeroA,
  output logic          zeroB
);
  localparam int F = W - 1;
  localparam logic [W-1:0] LOW_HALF = {{(W/2){1'b0}}, {(W/2){1'b1}}};

  logic [W-1:0] bEff;
  logic [W-1:0] shA;
  logic [W-1:0] shB;

  assign bEff = isDiv ? (opB & LOW_HALF) : opB;

  smdLod #(.W(W)) uLodA (.vec(opA),  .pos(expA), .isZero(zeroA));
  smdLod #(.W(W)) uLodB (.vec(bEff), .pos(expB), .isZero(zeroB));

  assign shA   = opA  << (KW'(F) - expA);
  assign shB   = bEff << (KW'(F) - expB);
  assign fracA = {1'b0, shA[W-2:0]};
  assign fracB = {1'b0, shB[W-2:0]};
endmodule

// File: rtl/smdAntiLog.sv
module smdAntiLog #(
  parameter int W = 8,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]   laneSum,
  input  logic [KW-1:0]  expA,
  input  logic [KW-1:0]  expB,
  input  logic           zeroA,
  input  logic           zeroB,
  input  logic           isDiv,
  output logic [2*W-1:0] laneRes
);
  localparam int F  = W - 1;
  localparam int EW = KW + 2;

  logic           topBit;
  logic [W-1:0]   mant;
  logic [EW-1:0]  eMul;
  logic [EW-1:0]  shr;
  logic [3*W-1:0] wide;
  logic [W-1:0]   quo;

  assign topBit = laneSum[F];
  assign mant   = topBit ? laneSum : {1'b1, laneSum[F-1:0]};
  assign eMul   = EW'(expA) + EW'(expB) + EW'(topBit);
  assign shr    = EW'(F) - EW'(expA) + EW'(expB) + EW'(topBit);
  assign wide   = ({{(2*W){1'b0}}, mant} << eMul) >> F;
  assign quo    = mant >> shr;

  always_comb begin
    if (isDiv) begin
      if (zeroB)      laneRes = {{W{1'b0}}, {W{1'b1}}};
      else if (zeroA) laneRes = '0;
      else            laneRes = {{W{1'b0}}, quo};
    end else begin
      if (zeroA || zeroB) laneRes = '0;
      else                laneRes = wide[2*W-1:0];
    end
  end
endmodule

// File: rtl/smdCtrl.sv
module smdCtrl
  import smdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [3:0]        precSel,
  input  logic [NSLICE-1:0] modeDiv,
  output ctrlS              ctl,
  output logic              validOut
);
  always_comb begin
    ctl.capture = validIn;
    unique case (precSel)
      4'b0010: ctl.cfg = CFG_M16;
      4'b0100: ctl.cfg = CFG_D16;
      4'b1000: ctl.cfg = CFG_S32;
      default: ctl.cfg = CFG_Q8;
    endcase
    unique case (ctl.cfg)
      CFG_M16: begin
        ctl.carryPass = 4'b0010;
        ctl.sliceDiv  = {modeDiv[3], modeDiv[2], modeDiv[0], modeDiv[0]};
      end
      CFG_D16: begin
        ctl.carryPass = 4'b1010;
        ctl.sliceDiv  = {modeDiv[2], modeDiv[2], modeDiv[0], modeDiv[0]};
      end
      CFG_S32: begin
        ctl.carryPass = 4'b1110;
        ctl.sliceDiv  = {NSLICE{modeDiv[0]}};
      end
      default: begin
        ctl.carryPass = 4'b0000;
        ctl.sliceDiv  = modeDiv;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/smdDatapath.sv
module smdDatapath
  import smdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [NSLICE-1:0] modeDiv,
  input  ctrlS              ctl,
  output logic [RES_W-1:0]  resOut
);
  localparam int W1 = SLICE_W;
  localparam int W2 = 2 * SLICE_W;
  localparam int W3 = 4 * SLICE_W;
  localparam int K1 = $clog2(W1);
  localparam int K2 = $clog2(W2);
  localparam int K3 = $clog2(W3);
  localparam int N2 = NSLICE / 2;

  logic [WORD_W-1:0] faPk, fbPk, sumPk;
  logic [RES_W-1:0]  resNext;

  // 8-bit lanes
  logic [W1-1:0]   fa1 [NSLICE];
  logic [W1-1:0]   fb1 [NSLICE];
  logic [K1-1:0]   ea1 [NSLICE];
  logic [K1-1:0]   eb1 [NSLICE];
  logic            za1 [NSLICE];
  logic            zb1 [NSLICE];
  logic [2*W1-1:0] r1  [NSLICE];
  for (genvar i = 0; i < NSLICE; i++) begin : gL8
    smdLogStage #(.W(W1)) uLog (
      .opA(opA[W1*i +: W1]), .opB(opB[W1*i +: W1]), .isDiv(modeDiv[i]),
      .fracA(fa1[i]), .fracB(fb1[i]), .expA(ea1[i]), .expB(eb1[i]),
      .zeroA(za1[i]), .zeroB(zb1[i]));
    smdAntiLog #(.W(W1)) uAnti (
      .laneSum(sumPk[W1*i +: W1]), .expA(ea1[i]), .expB(eb1[i]),
      .zeroA(za1[i]), .zeroB(zb1[i]), .isDiv(modeDiv[i]), .laneRes(r1[i]));
  end

  // 16-bit lanes
  logic [W2-1:0]   fa2 [N2];
  logic [W2-1:0]   fb2 [N2];
  logic [K2-1:0]   ea2 [N2];
  logic [K2-1:0]   eb2 [N2];
  logic            za2 [N2];
  logic            zb2 [N2];
  logic [2*W2-1:0] r2  [N2];
  for (genvar j = 0; j < N2; j++) begin : gL16
    smdLogStage #(.W(W2)) uLog (
      .opA(opA[W2*j +: W2]), .opB(opB[W2*j +: W2]), .isDiv(modeDiv[2*j]),
      .fracA(fa2[j]), .fracB(fb2[j]), .expA(ea2[j]), .expB(eb2[j]),
      .zeroA(za2[j]), .zeroB(zb2[j]));
    smdAntiLog #(.W(W2)) uAnti (
      .laneSum(sumPk[W2*j +: W2]), .expA(ea2[j]), .expB(eb2[j]),
      .zeroA(za2[j]), .zeroB(zb2[j]), .isDiv(modeDiv[2*j]), .laneRes(r2[j]));
  end

  // 32-bit lane
  logic [W3-1:0]   fa3, fb3;
  logic [K3-1:0]   ea3, eb3;
  logic            za3, zb3;
  logic [2*W3-1:0] r3;
  smdLogStage #(.W(W3)) uLog32 (
    .opA(opA), .opB(opB), .isDiv(modeDiv[0]),
    .fracA(fa3), .fracB(fb3), .expA(ea3), .expB(eb3),
    .zeroA(za3), .zeroB(zb3));
  smdAntiLog #(.W(W3)) uAnti32 (
    .laneSum(sumPk), .expA(ea3), .expB(eb3),
    .zeroA(za3), .zeroB(zb3), .isDiv(modeDiv[0]), .laneRes(r3));

  // fraction routing and result packing per layout
  always_comb begin
    unique case (ctl.cfg)
      CFG_M16: begin
        faPk    = {fa1[3], fa1[2], fa2[0]};
        fbPk    = {fb1[3], fb1[2], fb2[0]};
        resNext = {r1[3], r1[2], r2[0]};
      end
      CFG_D16: begin
        faPk    = {fa2[1], fa2[0]};
        fbPk    = {fb2[1], fb2[0]};
        resNext = {r2[1], r2[0]};
      end
      CFG_S32: begin
        faPk    = fa3;
        fbPk    = fb3;
        resNext = r3;
      end
      default: begin
        faPk    = {fa1[3], fa1[2], fa1[1], fa1[0]};
        fbPk    = {fb1[3], fb1[2], fb1[1], fb1[0]};
        resNext = {r1[3], r1[2], r1[1], r1[0]};
      end
    endcase
  end

  // 8-bit adder slices; carry crosses a slice edge only inside one lane
  always_comb begin
    logic [SLICE_W:0] part;
    logic             carry;
    carry = 1'b0;
    sumPk = '0;
    for (int s = 0; s < NSLICE; s++) begin
      carry = ctl.carryPass[s] ? carry : ctl.sliceDiv[s];
      part  = {1'b0, faPk[SLICE_W*s +: SLICE_W]}
            + {1'b0, fbPk[SLICE_W*s +: SLICE_W] ^ {SLICE_W{ctl.sliceDiv[s]}}}
            + (SLICE_W+1)'(carry);
      sumPk[SLICE_W*s +: SLICE_W] = part[SLICE_W-1:0];
      carry = part[SLICE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resOut <= '0;
    else if (ctl.capture) resOut <= resNext;
  end
endmodule

// File: rtl/smdMixArray.sv
module smdMixArray
  import smdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [3:0]  precSel,
  input  logic [3:0]  modeDiv,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        validOut,
  output logic [63:0] resOut
);
  ctrlS ctl;

  smdCtrl uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .precSel(precSel),
    .modeDiv(modeDiv), .ctl(ctl), .validOut(validOut));

  smdDatapath uDp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .modeDiv(modeDiv),
    .ctl(ctl), .resOut(resOut));
endmodule

// File: rtl/smdMixArrayChk.sv
module smdMixArrayChk (
  input logic        clk,
  input logic        rstN,
  input logic        validIn,
  input logic [3:0]  precSel,
  input logic [3:0]  modeDiv,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        validOut,
  input logic [63:0] resOut
);
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(resOut));

  p_div_zero_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && precSel == 4'b0001 && modeDiv[0] && opB[3:0] == 4'd0)
      |=> (resOut[15:0] == 16'h00FF));

  p_mul_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && precSel == 4'b0001 && !modeDiv[0] && opA[7:0] == 8'd0)
      |=> (resOut[15:0] == 16'h0000));

  p_div_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && precSel == 4'b0001 && modeDiv[1])
      |=> (resOut[31:24] == 8'h00));
endmodule

bind smdMixArray smdMixArrayChk uChk (.*);

// File: tb/tb_smdMixArray.sv
`timescale 1ns/1ps
module tb_smdMixArray;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [3:0]  precSel = 4'b0001;
  logic [3:0]  modeDiv = 4'b0000;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        validOut;
  logic [63:0] resOut;

  int checks = 0;
  int errors = 0;
  logic [63:0] expQ[$];
  string       tagQ[$];
  logic [63:0] lastExp = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  smdMixArray dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .precSel(precSel),
    .modeDiv(modeDiv), .opA(opA), .opB(opB), .validOut(validOut),
    .resOut(resOut));

  function automatic int msbPos(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [63:0] refMul(int w, logic [31:0] a, logic [31:0] b);
    int f, ka, kb, e;
    logic [127:0] fa, fb, s, m;
    if (a == 0 || b == 0) return 64'd0;
    f  = w - 1;
    ka = msbPos(a);
    kb = msbPos(b);
    fa = 128'(a - (32'd1 << ka)) << (f - ka);
    fb = 128'(b - (32'd1 << kb)) << (f - kb);
    s  = fa + fb;
    if (s < (128'd1 << f)) begin m = (128'd1 << f) + s; e = ka + kb; end
    else begin m = s; e = ka + kb + 1; end
    return 64'((m << e) >> f);
  endfunction

  function automatic logic [63:0] refDiv(int w, logic [31:0] a, logic [31:0] b);
    int f, ka, kb, sh;
    logic [31:0] bb;
    longint fa, fb, d, m;
    bb = b & ((32'd1 << (w / 2)) - 32'd1);
    if (bb == 0) return (64'd1 << w) - 64'd1;
    if (a == 0) return 64'd0;
    f  = w - 1;
    ka = msbPos(a);
    kb = msbPos(bb);
    fa = longint'({32'd0, a - (32'd1 << ka)}) << (f - ka);
    fb = longint'({32'd0, bb - (32'd1 << kb)}) << (f - kb);
    d  = fa - fb;
    if (d >= 0) begin m = (longint'(1) << f) + d; sh = f - ka + kb; end
    else begin m = (longint'(1) << (f + 1)) + d; sh = f - ka + kb + 1; end
    return 64'(m >> sh);
  endfunction

  function automatic logic [63:0] refWord(logic [3:0] p, logic [3:0] md,
                                          logic [31:0] a, logic [31:0] b);
    int base[4];
    int wid[4];
    int n;
    logic [31:0] msk, aL, bL;
    logic [63:0] r, acc;
    acc = '0;
    case (p)
      4'b0010: begin n = 3; base = '{0, 2, 3, 0}; wid = '{16, 8, 8, 0}; end
      4'b0100: begin n = 2; base = '{0, 2, 0, 0}; wid = '{16, 16, 0, 0}; end
      4'b1000: begin n = 1; base = '{0, 0, 0, 0}; wid = '{32, 0, 0, 0}; end
      default: begin n = 4; base = '{0, 1, 2, 3}; wid = '{8, 8, 8, 8}; end
    endcase
    for (int l = 0; l < n; l++) begin
      msk = (wid[l] == 32) ? 32'hFFFF_FFFF : ((32'd1 << wid[l]) - 32'd1);
      aL  = (a >> (8 * base[l])) & msk;
      bL  = (b >> (8 * base[l])) & msk;
      r   = md[base[l]] ? refDiv(wid[l], aL, bL) : refMul(wid[l], aL, bL);
      acc = acc | (r << (16 * base[l]));
    end
    return acc;
  endfunction

  task automatic send(input logic [3:0] p, input logic [3:0] md,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    precSel = p; modeDiv = md; opA = a; opB = b; validIn = 1'b1;
    expQ.push_back(refWord(p, md, a, b));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
    end
  endtask

  function automatic logic [31:0] nextRng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && validOut) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R8: validOut high with nothing pending, res=%h expected none", resOut);
        end else begin
          logic [63:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          lastExp = e;
          if (resOut !== e) begin
            errors++;
            $display("FAIL %s: resOut=%h expected %h", t, resOut, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] holdVal;
    opA = 32'hDEAD_BEEF; opB = 32'h0BAD_F00D;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    checks++;
    if (validOut !== 1'b0 || resOut !== 64'd0) begin
      errors++;
      $display("FAIL R10: validOut=%b resOut=%h expected 0 and 0", validOut, resOut);
    end

    // R4 / R6 / R7 quad multiply: max fractions, zero operand, known pair 43*10
    send(4'b0001, 4'b0000, {8'd255, 8'd128, 8'd43, 8'd0}, {8'd255, 8'd200, 8'd10, 8'd7}, "R4");
    send(4'b0001, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
    // R5 / R6 quad divide: divisor upper nibble ignored, divide by zero in lane 3
    send(4'b0001, 4'b1111, {8'd200, 8'd100, 8'd43, 8'd40}, {8'hF0, 8'h33, 8'hA0 | 8'd10, 8'd12}, "R5");
    send(4'b0001, 4'b0001, {8'd0, 8'd0, 8'd0, 8'd9}, {8'd5, 8'd0, 8'd3, 8'h50}, "R6");
    // R3 mixed modes in quad lanes, carries next to a divide lane (R7)
    send(4'b0001, 4'b0101, 32'hFF7F_FF81, 32'h0F0F_FF03, "R3");
    // R1 other layouts
    send(4'b0010, 4'b1001, 32'h0C30_ABCD, 32'h0507_00FF, "R1");
    send(4'b0100, 4'b0100, 32'hF00D_1234, 32'h00AB_5678, "R1");
    send(4'b1000, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
    send(4'b1000, 4'b0001, 32'h8765_4321, 32'hFFFF_0003, "R5");
    // R3 inner mode bits ignored
    send(4'b1000, 4'b1110, 32'h0001_2345, 32'h0000_0777, "R3");
    send(4'b0100, 4'b1010, 32'h1234_5678, 32'h0099_0033, "R3");
    // R2 illegal precision codes behave as four 8-bit lanes
    send(4'b0000, 4'b0011, 32'h7766_5544, 32'h0302_0105, "R2");
    send(4'b0110, 4'b1000, 32'h1122_3344, 32'h5566_7788, "R2");
    send(4'b1111, 4'b0000, 32'h8899_AABB, 32'hCCDD_EEFF, "R2");
    idle(3);

    // R9 hold while idle
    holdVal = lastExp;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      precSel = 4'b1000; modeDiv = 4'b1111; opA = nextRng(); opB = nextRng();
      @(negedge clk);
      checks++;
      if (resOut !== holdVal || validOut !== 1'b0) begin
        errors++;
        $display("FAIL R9: resOut=%h validOut=%b expected %h and 0", resOut, validOut, holdVal);
      end
    end

    // R1 randomized traffic across layouts and modes, back to back
    for (int i = 0; i < 200; i++) begin
      logic [31:0] c, a, b;
      logic [3:0] p;
      c = nextRng();
      a = nextRng();
      b = nextRng();
      case (c[1:0])
        2'd0: p = 4'b0001;
        2'd1: p = 4'b0010;
        2'd2: p = 4'b0100;
        default: p = c[3] ? 4'b1000 : c[7:4];
      endcase
      if (c[8]) a = a >> c[13:9];
      if (c[14]) b = b >> c[19:15];
      send(p, c[23:20], a, b, "R1");
      if (c[24]) idle(1);
    end
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d results missing, expected 0", expQ.size());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule